// File: doc/BRIEF.md
# Power-Managed System Clock Controller

This block produces a one-cycle system clock enable from three oscillator edge strobes: a fast crystal, an internal ring oscillator and a 32 kHz oscillator. Each strobe is a single-cycle pulse sampled on one always-running reference clock. A two-bit divide field, a low-power enable bit and a stop bit are written together through a small configuration port. When the low-power enable is clear, the divide field sets how many crystal edges make up one system clock. When the enable is set, the divide field selects either a divide-by-256 low-power mode or a mode that runs from the 32 kHz oscillator.

Stop mode turns the crystal off and halts the enable stream. It is left through an enabled wake pin, a real-time-clock alarm or reset. When the crystal restarts, a warm-up counter runs. A static option decides what happens during warm-up: either no enable pulses are issued until the warm-up completes, or the controller runs at once from the ring oscillator and moves to the crystal after warm-up. A switchback option lets selected interrupts clear the low-power enable in hardware, so the block returns to the fast divided rate.

Any change of clock source, mode or divide is applied only when an enable pulse is issued, or while no source is running. As a result a system clock period is never cut short.

Top module: `sysclk_pm`

## Requirements
- R1: With the low-power enable clear, one `sys_en` pulse is issued per 1, 2, 4 or 8 crystal strobes for divide field values 00, 01, 10 and 11.
- R2: With the low-power enable set and divide field 00, one pulse is issued per LP_DIV (256) crystal strobes.
- R3: With the low-power enable set and divide field 11, one pulse is issued per 32 kHz strobe, and `src` reads 3.
- R4: With the low-power enable set and divide field 01 or 10, the mode in force before the write is kept. `div_sel` still shows the written field.
- R5: A new mode or divide takes effect only at the next `sys_en` pulse. The period that is running when the write arrives completes at its old length.
- R6: When the stop bit is set, the next pulse boundary moves `src` to 0 (none). From then on `sys_en` stays low and `xtal_run` is low.
- R7: `wake_ext` or `rtc_alarm` clears a set stop bit in the next cycle. Reset also clears it.
- R8: `warm_done` is low while `xtal_run` is low. It rises after WARM_CYCLES crystal strobes once `xtal_run` is high.
- R9: While `warm_done` is low, `ring_start`=1 runs the divider from ring strobes with `src`=2, and the source moves to the crystal (`src`=1) at the first boundary after warm-up. With `ring_start`=0, no pulse is issued before `warm_done` rises.
- R10: If `swb_en` and `swb_irq` are both high while the low-power enable is set and a low-power mode is active, the enable clears in the next cycle. The divide field is kept, and the block returns to normal crystal division. With `swb_en` low, `swb_irq` has no effect.
- R11: During reset the outputs read: `pme`=0, `div_sel`=0, `stop_req`=0, `src`=0, `warm_done`=0, `xtal_run`=1, `sys_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Active-low reset |
| xtal_tick | input | 1 | Crystal edge strobe |
| ring_tick | input | 1 | Ring oscillator edge strobe |
| slow_tick | input | 1 | 32 kHz oscillator edge strobe |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_div | input | 2 | Divide field to write |
| cfg_pme | input | 1 | Low-power enable to write |
| cfg_stop | input | 1 | Stop bit to write |
| ring_start | input | 1 | 1: run from ring oscillator during warm-up |
| swb_en | input | 1 | Switchback enable |
| swb_irq | input | 1 | Enabled switchback interrupt pending |
| wake_ext | input | 1 | Enabled external wake interrupt |
| rtc_alarm | input | 1 | Real-time-clock alarm wake |
| sys_en | output | 1 | System clock enable pulse |
| src | output | 2 | Active source: 0 none, 1 crystal, 2 ring, 3 slow |
| warm_done | output | 1 | Crystal warm-up complete |
| xtal_run | output | 1 | Crystal oscillator enable |
| pme | output | 1 | Low-power enable state |
| div_sel | output | 2 | Divide field state |
| stop_req | output | 1 | Stop bit state |

## Verification
The assertions assume that each oscillator strobe is a single-cycle pulse. They also assume that the crystal strobe appears only while `xtal_run` is high, and that a wake or switchback request lasts one cycle. The bench generates the crystal strobe on every second reference cycle, and only when `xtal_run` is high. The ring strobe comes every third cycle and the 32 kHz strobe every fortieth. Configuration writes, wakes and interrupts are one-cycle pulses driven on the falling edge. Expected periods are products of the divide ratio and the strobe spacing.

// File: rtl/sysclk_pm.sv
`timescale 1ns/1ps
module sysclk_pm #(
  parameter int WARM_CYCLES = 65536,
  parameter int LP_DIV = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_tick,
  input  logic       ring_tick,
  input  logic       slow_tick,
  input  logic       cfg_we,
  input  logic [1:0] cfg_div,
  input  logic       cfg_pme,
  input  logic       cfg_stop,
  input  logic       ring_start,
  input  logic       swb_en,
  input  logic       swb_irq,
  input  logic       wake_ext,
  input  logic       rtc_alarm,
  output logic       sys_en,
  output logic [1:0] src,
  output logic       warm_done,
  output logic       xtal_run,
  output logic       pme,
  output logic [1:0] div_sel,
  output logic       stop_req
);
  localparam int CW = ($clog2(LP_DIV) > 3) ? $clog2(LP_DIV) : 3;
  localparam int WW = ($clog2(WARM_CYCLES) > 1) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [1:0] S_NONE = 2'd0, S_XTAL = 2'd1, S_RING = 2'd2, S_SLOW = 2'd3;

  typedef enum logic [1:0] {M_NORM, M_LP1, M_LP2} mode_t;

  mode_t tgt_mode, act_mode;
  logic [1:0] tgt_div, act_div, nsrc;
  logic [CW-1:0] cnt, lim;
  logic [WW-1:0] warm_cnt;
  logic tick, fire, upd, swb_hit, wake;

  assign swb_hit = swb_en && swb_irq && pme && act_mode != M_NORM;
  assign wake = wake_ext || rtc_alarm;
  assign xtal_run = !(stop_req && src == S_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pme <= 1'b0; div_sel <= 2'd0; stop_req <= 1'b0;
      tgt_mode <= M_NORM; tgt_div <= 2'd0;
    end else begin
      if (cfg_we) begin
        div_sel <= cfg_div;
        pme <= cfg_pme;
        stop_req <= cfg_stop;
        if (!cfg_pme) begin
          tgt_mode <= M_NORM;
          tgt_div <= cfg_div;
        end else if (cfg_div == 2'b00) tgt_mode <= M_LP1;
        else if (cfg_div == 2'b11) tgt_mode <= M_LP2;
      end
      if (swb_hit) begin
        pme <= 1'b0;
        tgt_mode <= M_NORM;
        tgt_div <= cfg_we ? cfg_div : div_sel;
      end
      if (stop_req && wake) stop_req <= 1'b0;
    end
  end

  always_comb begin
    case (act_mode)
      M_LP1:   lim = CW'(LP_DIV - 1);
      M_LP2:   lim = '0;
      default: lim = CW'((1 << act_div) - 1);
    endcase
    case (src)
      S_XTAL:  tick = xtal_tick;
      S_RING:  tick = ring_tick;
      S_SLOW:  tick = slow_tick;
      default: tick = 1'b0;
    endcase
  end

  assign nsrc = stop_req ? S_NONE :
                (tgt_mode == M_LP2) ? S_SLOW :
                warm_done ? S_XTAL :
                ring_start ? S_RING : S_NONE;
  assign fire = tick && cnt == lim;
  assign upd = fire || src == S_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= M_NORM; act_div <= 2'd0; src <= S_NONE;
      cnt <= '0; sys_en <= 1'b0;
    end else begin
      sys_en <= fire;
      if (upd) begin
        act_mode <= tgt_mode;
        act_div <= tgt_div;
        src <= nsrc;
        cnt <= '0;
      end else if (tick) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_cnt <= '0; warm_done <= 1'b0;
    end else if (!xtal_run) begin
      warm_cnt <= '0; warm_done <= 1'b0;
    end else if (!warm_done && xtal_tick) begin
      if (warm_cnt == WW'(WARM_CYCLES - 1)) warm_done <= 1'b1;
      else warm_cnt <= warm_cnt + 1'b1;
    end
  end

  a_r6_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && src == S_NONE) |=> !sys_en);
  a_r8_warm_needs_xtal: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_run |=> !warm_done);
  a_r9_xtal_after_warm: assert property (@(posedge clk) disable iff (!rst_n)
    (src == S_XTAL) |-> warm_done);
  a_r5_switch_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(src) && $past(src) != S_NONE) |-> sys_en);
  a_r10_switchback: assert property (@(posedge clk) disable iff (!rst_n)
    swb_hit |=> !pme);
  a_r10_div_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(div_sel));
  a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && wake) |=> !stop_req);
endmodule

// File: tb/sim_sysclk_pm.sv
`timescale 1ns/1ps
module sim_sysclk_pm;
  logic clk = 0, rst_n = 0;
  logic xtal_tick = 0, ring_tick = 0, slow_tick = 0;
  logic cfg_we = 0, cfg_pme = 0, cfg_stop = 0;
  logic [1:0] cfg_div = 0;
  logic ring_start = 0, swb_en = 0, swb_irq = 0, wake_ext = 0, rtc_alarm = 0;
  logic sys_en, warm_done, xtal_run, pme, stop_req;
  logic [1:0] src, div_sel;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sysclk_pm #(.WARM_CYCLES(16), .LP_DIV(256)) u0 (
    .clk, .rst_n, .xtal_tick, .ring_tick, .slow_tick, .cfg_we, .cfg_div, .cfg_pme,
    .cfg_stop, .ring_start, .swb_en, .swb_irq, .wake_ext, .rtc_alarm, .sys_en, .src,
    .warm_done, .xtal_run, .pme, .div_sel, .stop_req);

  int ph = 0;
  always @(negedge clk) begin
    ph = ph + 1;
    xtal_tick = xtal_run && (ph % 2 == 0);
    ring_tick = (ph % 3 == 0);
    slow_tick = (ph % 40 == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync();
    int n = 0;
    do begin @(negedge clk); n++; end while (!sys_en && n < 3000);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sys_en && n < 3000);
  endtask

  task automatic wr(input bit p, input logic [1:0] d, input bit s);
    cfg_pme = p; cfg_div = d; cfg_stop = s; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    int n, cnt;
    @(negedge clk); @(negedge clk);
    chk(pme == 0 && div_sel == 0 && stop_req == 0, "R11 cfg reset", {pme, div_sel, stop_req}, 0);
    chk(src == 0 && warm_done == 0 && sys_en == 0, "R11 src reset", {src, warm_done, sys_en}, 0);
    chk(xtal_run == 1, "R11 xtal_run", xtal_run, 1);
    rst_n = 1;
    cnt = 0; n = 0;
    while (!warm_done && n < 200) begin @(negedge clk); n++; if (sys_en) cnt++; end
    chk(cnt == 0, "R9 no pulse before warm", cnt, 0);
    chk(n >= 30 && n <= 36, "R8 warm time", n, 32);
    for (int d = 0; d < 4; d++) begin
      wr(0, 2'(d), 0);
      sync(); sync(); gap(n);
      chk(n == 2 * (1 << d), "R1 divide", n, 2 * (1 << d));
      chk(src == 1, "R1 src crystal", src, 1);
    end
    sync();
    wr(0, 2'd0, 0);
    gap(n); chk(n == 15, "R5 old period finishes", n, 15);
    gap(n); chk(n == 2, "R5 new period", n, 2);
    wr(1, 2'd0, 0);
    sync(); sync(); gap(n);
    chk(n == 512, "R2 divide-256", n, 512);
    wr(1, 2'd1, 0);
    sync(); gap(n);
    chk(n == 512, "R4 keep lp1 on 01", n, 512);
    chk(div_sel == 1, "R4 field shown", div_sel, 1);
    wr(1, 2'd3, 0);
    sync(); sync(); gap(n);
    chk(n == 40, "R3 slow period", n, 40);
    chk(src == 3, "R3 src slow", src, 3);
    wr(1, 2'd2, 0);
    sync(); gap(n);
    chk(n == 40, "R4 keep lp2 on 10", n, 40);
    swb_irq = 1; @(negedge clk); swb_irq = 0; @(negedge clk);
    chk(pme == 1, "R10 ignored without enable", pme, 1);
    swb_en = 1; swb_irq = 1; @(negedge clk); swb_irq = 0;
    chk(pme == 0, "R10 pme cleared", pme, 0);
    chk(div_sel == 2, "R10 field kept", div_sel, 2);
    sync(); sync(); gap(n);
    chk(n == 8, "R10 back to crystal divide", n, 8);
    chk(src == 1, "R10 src crystal", src, 1);
    wr(1, 2'd0, 0);
    sync(); sync();
    swb_irq = 1; @(negedge clk); swb_irq = 0;
    sync(); sync(); gap(n);
    chk(n == 2, "R10 from lp1", n, 2);
    swb_en = 0;
    wr(0, 2'd1, 1);
    repeat (20) @(negedge clk);
    chk(src == 0 && xtal_run == 0, "R6 stopped", {src, xtal_run}, 0);
    chk(warm_done == 0, "R8 warm cleared in stop", warm_done, 0);
    cnt = 0;
    repeat (200) begin @(negedge clk); if (sys_en) cnt++; end
    chk(cnt == 0, "R6 no pulses", cnt, 0);
    ring_start = 1;
    wake_ext = 1; @(negedge clk); wake_ext = 0;
    chk(stop_req == 0, "R7 wake pin", stop_req, 0);
    @(negedge clk); @(negedge clk);
    chk(src == 2, "R9 ring source", src, 2);
    sync(); gap(n);
    chk(n == 6, "R9 ring period", n, 6);
    n = 0;
    while (!warm_done && n < 200) begin @(negedge clk); n++; end
    chk(warm_done == 1, "R8 warm after wake", warm_done, 1);
    sync(); sync(); gap(n);
    chk(n == 4 && src == 1, "R9 moved to crystal", n, 4);
    ring_start = 0;
    wr(0, 2'd1, 1);
    repeat (20) @(negedge clk);
    rtc_alarm = 1; @(negedge clk); rtc_alarm = 0;
    chk(stop_req == 0, "R7 alarm wake", stop_req, 0);
    cnt = 0; n = 0;
    while (!warm_done && n < 200) begin @(negedge clk); n++; if (sys_en) cnt++; end
    chk(cnt == 0 && warm_done == 1, "R9 wait for warm", cnt, 0);
    sync(); gap(n);
    chk(n == 4, "R9 crystal after wait", n, 4);
    wr(0, 2'd0, 1);
    repeat (10) @(negedge clk);
    rst_n = 0; @(negedge clk);
    chk(stop_req == 0, "R7 reset exit", stop_req, 0);
    rst_n = 1;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule